// File: doc/BRIEF.md
# Read-Only Port Bus Bridge

This bridge joins a host expansion port, which can only issue read cycles, to a byte-wide I/O peripheral bus. The host selects a peripheral register through five host address bits. Host address bit 16 picks the window. A read-window access becomes a peripheral read, and the byte read back is returned on the upper half of the host data bus. A write-window access becomes a peripheral write. Because the host cannot drive data during such a cycle, the byte to write travels on host address bits 8..1.

The peripheral address is a fixed I/O base of 0x300 with the five selected bits in its low field. A 16-bit mode input changes both directions. In that mode a read-window access returns the whole 16-bit peripheral word to the host, and it also latches address bits 8..1 as a pending low byte. The next write-window access then carries the high byte and completes one 16-bit peripheral write. If that write finds no pending low byte, it still goes out with the stale latch contents, and a flag reports this.

Top module: `ro_port_bridge`

## Requirements
- R1: After reset, both peripheral strobes are high, both output enables are low, and the stale flag is low. The low-byte latch is reset to 0x00.
- R2: During an access, the peripheral address is 0x300 with host address bits 13..9 placed in its bits 4..0.
- R3: While the port select is high, host address bit 16 = 0 drives the active-low read strobe low on the first clock edge, and bit 16 = 1 drives the write strobe low instead. The two strobes are never low together. Both return high on the first clock edge after the select drops.
- R4: In byte mode, a read-window access drives host data bits 15..8 from peripheral data bits 7..0 and drives bits 7..0 as zero. The host data enable is high only while the read strobe is low.
- R5: In byte mode, a write-window access drives peripheral data bits 7..0 from host address bits 8..1 and drives bits 15..8 as zero. The peripheral data enable is high only while the write strobe is low.
- R6: In 16-bit mode, a read-window access returns the full 16-bit peripheral word on the host data bus.
- R7: In 16-bit mode, a read-window access latches host address bits 8..1 as the pending low byte. The next 16-bit write-window access drives peripheral data as {its own address bits 8..1, latched byte} and reports stale = 0.
- R8: In 16-bit mode, a write-window access with no pending low byte drives {address bits 8..1, current latch value} and raises the stale flag. Each write consumes the pending byte. The flag holds until the next write-window access.
- R9: A byte-mode read-window access changes neither the latched low byte nor its pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | Host port select, active high |
| host_addr_i | input | 17 | Host address; bit 16 is the window, bits 13..9 the register, bits 8..1 the write byte |
| wide_mode_i | input | 1 | 1 selects 16-bit behaviour |
| host_data_o | output | 16 | Data returned to the host |
| host_data_oe_o | output | 1 | Host data output enable |
| per_addr_o | output | 10 | Peripheral address |
| per_rd_no | output | 1 | Peripheral read strobe, active low |
| per_wr_no | output | 1 | Peripheral write strobe, active low |
| per_data_i | input | 16 | Data from the peripheral |
| per_data_o | output | 16 | Data to the peripheral |
| per_data_oe_o | output | 1 | Peripheral data output enable |
| stale_o | output | 1 | The last 16-bit write had no pending low byte |

## Verification
The bench builds the bridge with its default parameters. These are a 17-bit host address with the window on bit 16, a five-bit register field at bit 9, an eight-bit data byte at bit 1, a 10-bit peripheral address with base 0x300, and the byte-read lane in the upper half. With these values the extreme register codes 0x00 and 0x1F can be reached, as can the byte values 0x00 and 0xFF. The bench also exercises the ordered 16-bit sequences: write with no pending byte, read then write, a repeated write, and a byte read placed between the latch and the write.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic {WIN_RD = 1'b0, WIN_WR = 1'b1} win_e;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
#(
  parameter int HOST_AW = 17,
  parameter int WIN_BIT = 16,
  parameter int SEL_LSB = 9,
  parameter int SEL_W   = 5,
  parameter int DAT_LSB = 1,
  parameter int BYTE_W  = 8,
  parameter int PER_AW  = 10,
  parameter logic [PER_AW-1:0] IO_BASE = 10'h300
) (
  input  logic [HOST_AW-1:0] host_addr_i,
  output win_e               win_o,
  output logic [PER_AW-1:0]  per_addr_o,
  output logic [BYTE_W-1:0]  byte_o
);
  logic unused_addr;
  assign unused_addr = ^host_addr_i;

  assign win_o      = win_e'(host_addr_i[WIN_BIT]);
  assign per_addr_o = {IO_BASE[PER_AW-1:SEL_W], host_addr_i[SEL_LSB +: SEL_W]};
  assign byte_o     = host_addr_i[DAT_LSB +: BYTE_W];
endmodule

// File: rtl/br_strobe.sv
module br_strobe
  import br_pkg::*;
#(
  parameter int PER_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  win_e              win_i,
  input  logic [PER_AW-1:0] per_addr_i,
  output logic              start_o,
  output logic [PER_AW-1:0] per_addr_o,
  output logic              rd_no,
  output logic              wr_no
);
  logic sel_q, rd_n_q, wr_n_q;
  logic [PER_AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      addr_q <= '0;
    end else begin
      sel_q  <= sel_i;
      rd_n_q <= !(sel_i && win_i == WIN_RD);
      wr_n_q <= !(sel_i && win_i == WIN_WR);
      if (sel_i) addr_q <= per_addr_i;
    end
  end

  assign start_o    = sel_i && !sel_q;
  assign per_addr_o = addr_q;
  assign rd_no      = rd_n_q;
  assign wr_no      = wr_n_q;

  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_q && !wr_n_q));
  p_rd_go_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && win_i == WIN_RD) |=> !rd_n_q);
  p_wr_go_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && win_i == WIN_WR) |=> !wr_n_q);
  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (rd_n_q && wr_n_q));
endmodule

// File: rtl/br_lowlatch.sv
module br_lowlatch
  import br_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  win_e              win_i,
  input  logic              wide_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] wdata_o,
  output logic              stale_o
);
  logic [BYTE_W-1:0] lo_q;
  logic              pend_q, stale_q;
  logic [WORD_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
      wdata_q <= '0;
    end else if (start_i) begin
      if (win_i == WIN_RD) begin
        if (wide_i) begin
          lo_q   <= byte_i;
          pend_q <= 1'b1;
        end
      end else if (wide_i) begin
        wdata_q <= {byte_i, lo_q};
        stale_q <= !pend_q;
        pend_q  <= 1'b0;
      end else begin
        wdata_q <= {{BYTE_W{1'b0}}, byte_i};
        stale_q <= 1'b0;
      end
    end
  end

  assign wdata_o = wdata_q;
  assign stale_o = stale_q;

  p_stale_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && win_i == WIN_WR && wide_i && !pend_q) |=> stale_q);
  p_consume_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && win_i == WIN_WR && wide_i) |=> !pend_q);
  p_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && win_i == WIN_WR && wide_i) |=> (wdata_q[BYTE_W-1:0] == $past(lo_q)));
  p_byte_rd_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && win_i == WIN_RD && !wide_i) |=> ($stable(lo_q) && $stable(pend_q)));
endmodule

// File: rtl/ro_port_bridge.sv
module ro_port_bridge
  import br_pkg::*;
#(
  parameter int HOST_AW = 17,
  parameter int WIN_BIT = 16,
  parameter int SEL_LSB = 9,
  parameter int SEL_W   = 5,
  parameter int DAT_LSB = 1,
  parameter int BYTE_W  = 8,
  parameter int PER_AW  = 10,
  parameter logic [PER_AW-1:0] IO_BASE = 10'h300,
  parameter bit RD_LANE_HI = 1'b1,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_sel_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic               wide_mode_i,
  output logic [WORD_W-1:0]  host_data_o,
  output logic               host_data_oe_o,
  output logic [PER_AW-1:0]  per_addr_o,
  output logic               per_rd_no,
  output logic               per_wr_no,
  input  logic [WORD_W-1:0]  per_data_i,
  output logic [WORD_W-1:0]  per_data_o,
  output logic               per_data_oe_o,
  output logic               stale_o
);
  win_e              win;
  logic [PER_AW-1:0] dec_addr;
  logic [BYTE_W-1:0] dec_byte;
  logic              start;
  logic              wide_q;
  logic [WORD_W-1:0] wdata;
  logic [WORD_W-1:0] byte_rd;

  br_decode #(
    .HOST_AW(HOST_AW), .WIN_BIT(WIN_BIT), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W),
    .DAT_LSB(DAT_LSB), .BYTE_W(BYTE_W), .PER_AW(PER_AW), .IO_BASE(IO_BASE)
  ) u_decode (
    .host_addr_i(host_addr_i),
    .win_o      (win),
    .per_addr_o (dec_addr),
    .byte_o     (dec_byte)
  );

  br_strobe #(.PER_AW(PER_AW)) u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (host_sel_i),
    .win_i     (win),
    .per_addr_i(dec_addr),
    .start_o   (start),
    .per_addr_o(per_addr_o),
    .rd_no     (per_rd_no),
    .wr_no     (per_wr_no)
  );

  br_lowlatch #(.BYTE_W(BYTE_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .win_i  (win),
    .wide_i (wide_mode_i),
    .byte_i (dec_byte),
    .wdata_o(wdata),
    .stale_o(stale_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wide_q <= 1'b0;
    else if (start) wide_q <= wide_mode_i;
  end

  // byte reads land on one half of the host bus, chosen at build time
  generate
    if (RD_LANE_HI) begin : g_lane_hi
      assign byte_rd = {per_data_i[BYTE_W-1:0], {BYTE_W{1'b0}}};
    end else begin : g_lane_lo
      assign byte_rd = {{BYTE_W{1'b0}}, per_data_i[BYTE_W-1:0]};
    end
  endgenerate

  assign host_data_oe_o = !per_rd_no;
  assign host_data_o    = !per_rd_no ? (wide_q ? per_data_i : byte_rd) : '0;
  assign per_data_oe_o  = !per_wr_no;
  assign per_data_o     = !per_wr_no ? wdata : '0;

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!per_rd_no && host_sel_i) |=> $stable(per_addr_o));
endmodule

// File: tb/ro_port_bridge_bench.sv
module ro_port_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0;
  logic [16:0] host_addr = '0;
  logic        wide_mode = 1'b0;
  logic [15:0] host_data;
  logic        host_oe;
  logic [9:0]  per_addr;
  logic        per_rd_n, per_wr_n;
  logic [15:0] per_din = '0;
  logic [15:0] per_dout;
  logic        per_oe;
  logic        stale;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // in-access and after-release observations
  logic        a_rd, a_wr, a_poe, a_hoe, a_stale;
  logic [9:0]  a_addr;
  logic [15:0] a_pdata, a_hdata;
  logic        r_rd, r_wr, r_poe, r_hoe;

  always #2 clk = ~clk;

  ro_port_bridge u_ro_port_bridge (
    .clk_i(clk), .rst_ni(rst_n), .host_sel_i(host_sel), .host_addr_i(host_addr),
    .wide_mode_i(wide_mode), .host_data_o(host_data), .host_data_oe_o(host_oe),
    .per_addr_o(per_addr), .per_rd_no(per_rd_n), .per_wr_no(per_wr_n),
    .per_data_i(per_din), .per_data_o(per_dout), .per_data_oe_o(per_oe),
    .stale_o(stale)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_acc(input logic win, input logic wide, input logic [4:0] r,
                         input logic [7:0] b);
    @(negedge clk);
    host_sel  = 1'b1;
    host_addr = {win, 2'b00, r, b, 1'b0};
    wide_mode = wide;
    @(posedge clk);
    @(negedge clk);
    a_rd = per_rd_n; a_wr = per_wr_n; a_addr = per_addr; a_pdata = per_dout;
    a_poe = per_oe; a_hdata = host_data; a_hoe = host_oe; a_stale = stale;
    host_sel  = 1'b0;
    host_addr = '0;
    @(posedge clk);
    @(negedge clk);
    r_rd = per_rd_n; r_wr = per_wr_n; r_poe = per_oe; r_hoe = host_oe;
  endtask

  task automatic t_reset;
    chk("R1 rd strobe", per_rd_n, 1);
    chk("R1 wr strobe", per_wr_n, 1);
    chk("R1 per oe", per_oe, 0);
    chk("R1 host oe", host_oe, 0);
    chk("R1 stale", stale, 0);
  endtask

  task automatic t_byte_read;
    per_din = 16'h12A5;
    run_acc(1'b0, 1'b0, 5'h05, 8'h00);
    chk("R2 addr rd", a_addr, 10'h305);
    chk("R3 rd low", a_rd, 0);
    chk("R3 wr high on read", a_wr, 1);
    chk("R4 host data", a_hdata, 16'hA500);
    chk("R4 host oe", a_hoe, 1);
    chk("R5 per oe idle on read", a_poe, 0);
    chk("R3 rd release", r_rd, 1);
    chk("R4 host oe release", r_hoe, 0);
  endtask

  task automatic t_byte_write;
    run_acc(1'b1, 1'b0, 5'h1F, 8'h3C);
    chk("R2 addr wr", a_addr, 10'h31F);
    chk("R3 wr low", a_wr, 0);
    chk("R3 rd high on write", a_rd, 1);
    chk("R5 per data", a_pdata, 16'h003C);
    chk("R5 per oe", a_poe, 1);
    chk("R4 host oe idle on write", a_hoe, 0);
    chk("R3 wr release", r_wr, 1);
    chk("R5 per oe release", r_poe, 0);
    run_acc(1'b1, 1'b0, 5'h00, 8'hFF);
    chk("R2 addr base", a_addr, 10'h300);
    chk("R5 per data ff", a_pdata, 16'h00FF);
  endtask

  task automatic t_wide_no_pending;
    run_acc(1'b1, 1'b1, 5'h02, 8'h7E);
    chk("R8 data reset latch", a_pdata, 16'h7E00);
    chk("R8 stale set", a_stale, 1);
  endtask

  task automatic t_wide_pair;
    per_din = 16'hBEEF;
    run_acc(1'b0, 1'b1, 5'h02, 8'h44);
    chk("R6 wide read", a_hdata, 16'hBEEF);
    chk("R6 host oe", a_hoe, 1);
    chk("R8 stale held over read", a_stale, 1);
    run_acc(1'b1, 1'b1, 5'h02, 8'h99);
    chk("R7 pair data", a_pdata, 16'h9944);
    chk("R7 stale clear", a_stale, 0);
    chk("R7 wr low", a_wr, 0);
    run_acc(1'b1, 1'b1, 5'h02, 8'h11);
    chk("R8 repeat data", a_pdata, 16'h1144);
    chk("R8 repeat stale", a_stale, 1);
  endtask

  task automatic t_byte_read_keeps_latch;
    per_din = 16'h0000;
    run_acc(1'b0, 1'b1, 5'h03, 8'h5A);
    per_din = 16'h77C3;
    run_acc(1'b0, 1'b0, 5'h03, 8'hEE);
    chk("R4 byte read after wide", a_hdata, 16'hC300);
    run_acc(1'b1, 1'b1, 5'h03, 8'h66);
    chk("R9 latch kept", a_pdata, 16'h665A);
    chk("R9 pending kept", a_stale, 0);
    run_acc(1'b1, 1'b0, 5'h03, 8'h01);
    chk("R5 byte write after wide", a_pdata, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_read();
    t_byte_write();
    t_wide_no_pending();
    t_wide_pair();
    t_byte_read_keeps_latch();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule